// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between memory locations on behalf of two independent channels. Each channel waits for a request pulse. It then asks for the bus and, once granted, performs one read from its source address followed by one write to its destination address. After that single move it gives the bus back, so the processor loses only two bus cycles per transfer. Addresses are 20 bits wide. The unit moved is one byte or one halfword. At most one side of a channel advances through memory, and the other side stays on a fixed address.

Software programs each channel through a small register port. Each channel has a source register, a destination register, a reload register, a readable transfer counter and a control register. When the channel is enabled, its first transfer copies the reload value into the counter. It also copies the advancing side's register into a private working pointer. Every later transfer advances that pointer and decrements the counter. When the counter steps below zero, the channel raises a one-cycle interrupt pulse. It then either switches itself off (single mode) or reloads the counter and keeps running (repeat mode).

Top module: `dma_steal_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0, `bus_req`, `mem_rd`, `mem_wr` and both `irq` bits are low.
- R2: A transfer raises `bus_req` and holds it until `bus_gnt` is seen. It then spends exactly one cycle with `mem_rd` high at the source address and the next cycle with `mem_wr` high at the destination address, carrying the data read. It then drops `bus_req`. `mem_rd` and `mem_wr` are never high together.
- R3: The advancing side's address moves up by 1 per byte transfer or by 2 per halfword transfer (`mem_half`=1, data in `mem_wdata[15:8]` and `mem_wdata[7:0]`, low byte at the lower address). A side that is not advancing keeps the same address on every transfer.
- R4: The first transfer after the enable bit goes from 0 to 1 starts the advancing side at its programmed register value and loads the counter from the reload register. A counter value N therefore gives N+1 transfers before underflow.
- R5: In single mode (control bit 1 = 0), the transfer that underflows the counter clears the enable bit. Later requests then cause no bus activity.
- R6: In repeat mode (control bit 1 = 1), underflow reloads the counter from the reload register, and the enable bit stays 1.
- R7: `irq[c]` is high for exactly one cycle, once per counter underflow of channel c, and at no other time.
- R8: A channel whose control bits 3 and 4 are both 1 is illegal. Its requests are dropped and no bus cycle is made for it.
- R9: Register map: `reg_addr[3]` selects the channel, and `reg_addr[2:0]` selects the register: 0 source, 1 destination, 2 reload, 3 counter (read only), 4 control. Control bits are: bit0 enable, bit1 repeat, bit2 halfword, bit3 source advances, bit4 destination advances. The source register can be written only while bit3 is 1 or the enable bit is 0. The destination register follows the same rule with bit4. The reload and control registers are always writable.
- R10: All registers read back at any time. While enabled, reading the advancing side's register returns the channel's working pointer, that is, the address its next transfer will use.
- R11: When both channels are pending in the same cycle, channel 0 is served first. A request that arrives while a transfer is running is held and served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select: channel bit and offset |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data (combinational) |
| dreq | input | 2 | Per-channel transfer request, one bit per channel |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | 20 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_half | output | 1 | 1 for a halfword access, 0 for a byte access |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the cycle `mem_rd` is high |
| irq | output | 2 | Per-channel underflow pulse |

## Verification
The assertions assume that memory returns read data in the same cycle as `mem_rd`. They also assume that software does not rewrite a channel's control register during the cycles in which that channel's own move is in flight. Under those conditions, underflow, mode and enable stay consistent with each other. The bench therefore changes control values only after waiting long enough for every started transfer to finish. It models a memory that answers combinationally and drives the grant from `bus_req`, except in the one scenario that withholds grant on purpose.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    localparam int NCH     = 2;
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int ADDR_W  = 20;
    localparam int CNT_W   = 16;
    localparam int DATA_W  = 16;
    localparam int OFF_W   = 3;
    localparam int RADDR_W = CH_W + OFF_W;
    localparam int REG_W   = ADDR_W;

    localparam logic [OFF_W-1:0] OFF_SRC = 3'd0;
    localparam logic [OFF_W-1:0] OFF_DST = 3'd1;
    localparam logic [OFF_W-1:0] OFF_RLD = 3'd2;
    localparam logic [OFF_W-1:0] OFF_CNT = 3'd3;
    localparam logic [OFF_W-1:0] OFF_CTL = 3'd4;

    typedef struct packed {
        logic dst_fwd;
        logic src_fwd;
        logic unit16;
        logic repeat_m;
        logic enable;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } xfer_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              unit16;
    } xfer_desc_t;

    function automatic logic [ADDR_W-1:0] fwd_step(input logic [ADDR_W-1:0] a,
                                                   input logic unit16);
        return a + {{(ADDR_W-2){1'b0}}, unit16, ~unit16};
    endfunction

endpackage

// File: rtl/dma_req_arb.sv
module dma_req_arb
    import dma_steal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  pend,
    input  logic            idle,
    output logic [NCH-1:0]  gnt,
    output logic [CH_W-1:0] gnt_idx,
    output logic            any
);
    logic found;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (pend[i] && !found) begin
                gnt[i]  = idle;
                gnt_idx = CH_W'(i);
                found   = 1'b1;
            end
        end
    end

    assign any = found && idle;

    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    assert_low_index_first_R11: assert property (@(posedge clk) disable iff (rst)
        (pend[0] && idle) |-> (gnt[0] && gnt_idx == '0));

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_steal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CH_W-1:0]   start_idx,
    input  xfer_desc_t        desc_in,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_half,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NCH-1:0]    done,
    output logic              idle
);
    xfer_st_e          st_q;
    logic [CH_W-1:0]   idx_q;
    xfer_desc_t        desc_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            desc_q <= '0;
            data_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    st_q   <= ST_WAIT;
                    idx_q  <= start_idx;
                    desc_q <= desc_in;
                end
                ST_WAIT: if (bus_gnt) st_q <= ST_READ;
                ST_READ: begin
                    data_q <= mem_rdata;
                    st_q   <= ST_WRITE;
                end
                ST_WRITE: st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    assign idle      = (st_q == ST_IDLE);
    assign bus_req   = !idle;
    assign mem_rd    = (st_q == ST_READ);
    assign mem_wr    = (st_q == ST_WRITE);
    assign mem_addr  = mem_rd ? desc_q.src : desc_q.dst;
    assign mem_half  = desc_q.unit16;
    assign mem_wdata = data_q;

    always_comb begin
        done = '0;
        for (int i = 0; i < NCH; i++) begin
            if (mem_wr && idx_q == CH_W'(i)) done[i] = 1'b1;
        end
    end

    assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    assert_rd_then_wr_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mem_wr && !mem_rd));
    assert_rd_after_gnt_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd) |-> $past(bus_gnt));
    assert_release_after_wr_R2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !bus_req);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_steal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             req,
    input  logic             take,
    input  logic             done,
    output logic             pend,
    output xfer_desc_t       desc,
    output logic             irq
);
    logic [ADDR_W-1:0] src_q, dst_q, fwd_q;
    logic [CNT_W-1:0]  rld_q, cnt_q;
    ctl_t              ctl_q;
    logic              first_q, pend_q, irq_q;

    logic              legal, active;
    logic [ADDR_W-1:0] first_ptr, cur_ptr;
    logic [CNT_W-1:0]  cur_cnt;
    logic              underflow;

    assign legal     = !(ctl_q.src_fwd && ctl_q.dst_fwd);
    assign active    = ctl_q.enable && legal;
    assign first_ptr = ctl_q.src_fwd ? src_q : dst_q;
    assign cur_ptr   = first_q ? first_ptr : fwd_q;
    assign cur_cnt   = first_q ? rld_q : cnt_q;
    assign underflow = done && (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            dst_q   <= '0;
            fwd_q   <= '0;
            rld_q   <= '0;
            cnt_q   <= '0;
            ctl_q   <= '0;
            first_q <= 1'b0;
            pend_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q  <= 1'b0;
            pend_q <= active ? ((pend_q && !take) || req) : 1'b0;
            if (wr_en) begin
                unique case (off)
                    OFF_SRC: if (ctl_q.src_fwd || !ctl_q.enable) src_q <= wdata;
                    OFF_DST: if (ctl_q.dst_fwd || !ctl_q.enable) dst_q <= wdata;
                    OFF_RLD: rld_q <= wdata[CNT_W-1:0];
                    OFF_CTL: begin
                        ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
                        if (wdata[0] && !ctl_q.enable) first_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (done) begin
                fwd_q   <= fwd_step(cur_ptr, ctl_q.unit16);
                first_q <= 1'b0;
                if (underflow) begin
                    irq_q <= 1'b1;
                    if (ctl_q.repeat_m) begin
                        cnt_q <= rld_q;
                    end else begin
                        cnt_q        <= '0;
                        ctl_q.enable <= 1'b0;
                    end
                end else begin
                    cnt_q <= cur_cnt - 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (off)
            OFF_SRC: rdata = (ctl_q.enable && ctl_q.src_fwd) ? cur_ptr : src_q;
            OFF_DST: rdata = (ctl_q.enable && ctl_q.dst_fwd) ? cur_ptr : dst_q;
            OFF_RLD: rdata = REG_W'(rld_q);
            OFF_CNT: rdata = REG_W'(cnt_q);
            OFF_CTL: rdata = REG_W'(ctl_q);
            default: rdata = '0;
        endcase
    end

    assign pend        = pend_q;
    assign irq         = irq_q;
    assign desc.src    = ctl_q.src_fwd ? cur_ptr : src_q;
    assign desc.dst    = ctl_q.dst_fwd ? cur_ptr : dst_q;
    assign desc.unit16 = ctl_q.unit16;

    assert_irq_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);
    assert_single_stops_R5: assert property (@(posedge clk) disable iff (rst)
        (done && cur_cnt == '0 && !ctl_q.repeat_m && !wr_en) |=> !ctl_q.enable);
    assert_repeat_stays_R6: assert property (@(posedge clk) disable iff (rst)
        (done && ctl_q.repeat_m && ctl_q.enable && !wr_en) |=> ctl_q.enable);
    assert_fixed_src_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == OFF_SRC && !ctl_q.src_fwd && ctl_q.enable) |=> $stable(src_q));
    assert_fixed_dst_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == OFF_DST && !ctl_q.dst_fwd && ctl_q.enable) |=> $stable(dst_q));
    assert_illegal_no_pend_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.src_fwd && ctl_q.dst_fwd) |=> !pend_q);

endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
    import dma_steal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NCH-1:0]     dreq,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               mem_half,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [NCH-1:0]     irq
);
    logic [CH_W-1:0]  reg_ch;
    logic [OFF_W-1:0] reg_off;
    logic [REG_W-1:0] rd_arr   [NCH];
    xfer_desc_t       desc_arr [NCH];
    logic [NCH-1:0]   pend, take, done;
    logic [CH_W-1:0]  gnt_idx;
    logic             start, idle;

    assign reg_ch  = reg_addr[RADDR_W-1:OFF_W];
    assign reg_off = reg_addr[OFF_W-1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dma_chan_regs u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr_en (reg_wr && reg_ch == CH_W'(c)),
            .off   (reg_off),
            .wdata (reg_wdata),
            .rdata (rd_arr[c]),
            .req   (dreq[c]),
            .take  (take[c]),
            .done  (done[c]),
            .pend  (pend[c]),
            .desc  (desc_arr[c]),
            .irq   (irq[c])
        );
    end

    assign reg_rdata = rd_arr[reg_ch];

    dma_req_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .idle    (idle),
        .gnt     (take),
        .gnt_idx (gnt_idx),
        .any     (start)
    );

    dma_xfer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_idx (gnt_idx),
        .desc_in   (desc_arr[gnt_idx]),
        .bus_gnt   (bus_gnt),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_half  (mem_half),
        .mem_wdata (mem_wdata),
        .done      (done),
        .idle      (idle)
    );

endmodule

// File: tb/sim_dma_steal_ctrl.sv
module sim_dma_steal_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [19:0] reg_wdata = '0;
    logic [19:0] reg_rdata;
    logic [1:0]  dreq = '0;
    logic        bus_req, bus_gnt, mem_rd, mem_wr, mem_half;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [1:0]  irq;
    logic        gnt_en = 1'b1;

    logic [7:0]  mem  [256];
    logic [7:0]  wlog [64];
    int          wn = 0, rd_n = 0, irq0_n = 0, irq1_n = 0;
    int          checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_gnt   = bus_req && gnt_en;
    assign mem_rdata = {mem_half ? mem[mem_addr[7:0] + 8'd1] : 8'h00, mem[mem_addr[7:0]]};

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_half) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
            wlog[wn % 64] <= mem_wdata[7:0];
            wn <= wn + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd) rd_n++;
            if (irq[0]) irq0_n++;
            if (irq[1]) irq1_n++;
        end
    end

    dma_steal_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_half(mem_half),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [19:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [3:0] a, output logic [19:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input logic [1:0] m, input int wait_n);
        @(negedge clk);
        dreq = m;
        @(negedge clk);
        dreq = '0;
        repeat (wait_n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [19:0] v;
        rreg(4'd4, v);  check("R1", "ch0 control", v, 0);
        rreg(4'd12, v); check("R1", "ch1 control", v, 0);
        rreg(4'd0, v);  check("R1", "ch0 source", v, 0);
        check("R1", "bus outputs", {bus_req, mem_rd, mem_wr, irq}, 0);
    endtask

    task automatic t_single();
        logic [19:0] v;
        int r0, i0;
        mem[8'h10] = 8'hA1; mem[8'h11] = 8'hA2; mem[8'h12] = 8'hA3;
        wreg(4'd0, 20'h10); wreg(4'd1, 20'h80); wreg(4'd2, 20'd2);
        i0 = irq0_n;
        wreg(4'd4, 20'h09);
        rreg(4'd0, v); check("R10", "pointer before first move", v, 20'h10);
        pulse(2'b01, 8);
        check("R4", "first byte from programmed source", mem[8'h80], 8'hA1);
        rreg(4'd0, v); check("R3", "byte step of pointer", v, 20'h11);
        pulse(2'b01, 8);
        check("R3", "second byte", mem[8'h80], 8'hA2);
        rreg(4'd3, v); check("R4", "counter after two moves", v, 0);
        check("R7", "no irq before underflow", irq0_n - i0, 0);
        pulse(2'b01, 8);
        check("R4", "third move is N+1", mem[8'h80], 8'hA3);
        check("R7", "one irq on underflow", irq0_n - i0, 1);
        rreg(4'd4, v); check("R5", "enable cleared", v, 20'h08);
        r0 = rd_n;
        pulse(2'b01, 8);
        check("R5", "no move after stop", rd_n - r0, 0);
        rreg(4'd0, v); check("R10", "source register when disabled", v, 20'h10);
        wreg(4'd4, 20'h09);
        pulse(2'b01, 8);
        check("R4", "restart reloads pointer", mem[8'h80], 8'hA1);
        rreg(4'd3, v); check("R4", "restart reloads counter", v, 1);
        wreg(4'd4, 20'h00);
    endtask

    task automatic t_half();
        logic [19:0] v;
        int i1;
        mem[8'h20] = 8'h34; mem[8'h21] = 8'h12;
        wreg(4'd8, 20'h20); wreg(4'd9, 20'h40); wreg(4'd10, 20'd1);
        i1 = irq1_n;
        wreg(4'd12, 20'h15);
        pulse(2'b10, 8);
        check("R3", "halfword low byte", mem[8'h40], 8'h34);
        check("R3", "halfword high byte", mem[8'h41], 8'h12);
        rreg(4'd9, v); check("R10", "destination pointer +2", v, 20'h42);
        pulse(2'b10, 8);
        check("R3", "second halfword at +2", {mem[8'h43], mem[8'h42]}, 16'h1234);
        check("R7", "ch1 irq", irq1_n - i1, 1);
        rreg(4'd12, v); check("R5", "ch1 stopped", v, 20'h14);
    endtask

    task automatic t_repeat();
        logic [19:0] v;
        int i0;
        mem[8'h30] = 8'h5A;
        wreg(4'd0, 20'h30); wreg(4'd1, 20'h50); wreg(4'd2, 20'd1);
        i0 = irq0_n;
        wreg(4'd4, 20'h03);
        for (int k = 0; k < 4; k++) pulse(2'b01, 8);
        check("R7", "two underflows in four moves", irq0_n - i0, 2);
        rreg(4'd4, v); check("R6", "still enabled", v, 20'h03);
        rreg(4'd3, v); check("R6", "counter reloaded", v, 1);
        check("R3", "fixed to fixed copy", mem[8'h50], 8'h5A);
        wreg(4'd4, 20'h00);
    endtask

    task automatic t_illegal();
        int r0;
        r0 = rd_n;
        wreg(4'd12, 20'h19);
        pulse(2'b10, 8);
        check("R8", "both advancing gives no move", rd_n - r0, 0);
        wreg(4'd12, 20'h00);
    endtask

    task automatic t_protect();
        logic [19:0] v;
        wreg(4'd1, 20'h80); wreg(4'd0, 20'h10);
        wreg(4'd4, 20'h09);
        wreg(4'd1, 20'h99);
        rreg(4'd1, v); check("R9", "fixed register locked", v, 20'h80);
        wreg(4'd0, 20'h60);
        rreg(4'd0, v); check("R9", "advancing register writable", v, 20'h60);
        wreg(4'd4, 20'h00);
        rreg(4'd0, v); check("R9", "advancing register kept", v, 20'h60);
        wreg(4'd1, 20'h90);
        rreg(4'd1, v); check("R9", "fixed writable when off", v, 20'h90);
    endtask

    task automatic t_prio();
        int w0, i0, i1;
        mem[8'h70] = 8'hC0; mem[8'h71] = 8'hC1;
        wreg(4'd0, 20'h70); wreg(4'd1, 20'h90); wreg(4'd2, 20'd0);
        wreg(4'd8, 20'h71); wreg(4'd9, 20'h90); wreg(4'd10, 20'd0);
        wreg(4'd4, 20'h01); wreg(4'd12, 20'h01);
        w0 = wn; i0 = irq0_n; i1 = irq1_n;
        pulse(2'b11, 14);
        check("R11", "channel 0 served first", wlog[w0 % 64], 8'hC0);
        check("R11", "held channel 1 served next", wlog[(w0 + 1) % 64], 8'hC1);
        check("R7", "one irq per channel", (irq0_n - i0) * 16 + (irq1_n - i1), 17);
    endtask

    task automatic t_grant();
        int r0;
        wreg(4'd0, 20'h70); wreg(4'd1, 20'h91); wreg(4'd4, 20'h01);
        gnt_en = 1'b0;
        r0 = rd_n;
        pulse(2'b01, 6);
        check("R2", "request held without grant", bus_req, 1);
        check("R2", "no read without grant", rd_n - r0, 0);
        gnt_en = 1'b1;
        repeat (8) @(negedge clk);
        check("R2", "one read after grant", rd_n - r0, 1);
        check("R2", "data written", mem[8'h91], 8'hC0);
        check("R2", "bus released", bus_req, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_half();
        t_repeat();
        t_illegal();
        t_protect();
        t_prio();
        t_grant();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule